// File: doc/BRIEF.md
# Multi-CPU First-Level Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt sources and presents them to several processors. The sources are grouped thirty-two to a word. Every processor owns a private register bank. For each source group the bank holds one read/write enable word and one read-only status word. Each processor has one interrupt line, and that line is high whenever any source is both pending and enabled in that processor's bank.

Software reaches every bank over a simple 32-bit register bus with a word address. A read returns data one cycle after the strobe. Banks are packed back to back. In each bank the enable words come first and the status words follow. Within each of the two runs, the lowest address holds the highest-numbered source group. An enable word is always written whole; there are no set-bit or clear-bit registers. Keeping a source on one processor is the job of software. The hardware asserts every processor whose bank enables a pending source.

Top module: `l1ic_top`

## Requirements
- R1: After reset, every enable word in every bank reads zero and every interrupt output is low.
- R2: With W = NUM_WORDS, word offset o of a bank, for o below W, is a read/write enable word for source group W-1-o. A write replaces all 32 bits, and a read returns the last value written. Group g covers sources 32g to 32g+31, with bit b standing for source 32g+b.
- R3: Word offset W+j of a bank, for j from 0 to W-1, returns the synchronised level of source group W-1-j. A source change is visible to a read strobe issued two cycles after the change.
- R4: A write to a status offset changes no enable word and no status word.
- R5: Interrupt output k is registered and equals the OR over all groups of (status AND enable of bank k). It rises three clock edges after a source rises, and one edge after the enable write that unmasks a pending source.
- R6: Bank k begins at word address k*2*W. A write to one bank leaves every other bank unchanged.
- R7: A source that is enabled in several banks asserts every one of those processors' outputs at the same time.
- R8: Word addresses at or above NUM_CPUS*2*W read as zero, and writes to them change nothing.
- R9: Read data is captured on the edge where rd_en is sampled high and is held until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32*NUM_WORDS | Level interrupt sources, asynchronous |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_out | output | NUM_CPUS | One interrupt line per processor |

## Verification
A corrupted enable bit appears in two places: on the enable readback at the next read, and on the interrupt line of the affected processor one edge after the bit changes, provided its source is high. A wrong group or bank decode shows up at once. The write lands in a neighbouring group or processor, so the readback of that word and the interrupt line go wrong together. A reversed group order or a missing synchroniser stage shows up as a status readback that does not match the source, or as an interrupt line that is one cycle early or late against the three-edge path.

// File: rtl/l1ic_pkg.sv
package l1ic_pkg;
  localparam int SRC_PER_WORD = 32;
  typedef logic [SRC_PER_WORD-1:0] word_t;

  // Bus words occupied by one processor's bank
  function automatic int bank_words(input int n_words);
    return 2 * n_words;
  endfunction
endpackage

// File: rtl/l1ic_sync.sv
module l1ic_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign d_out = sync_q;
endmodule

// File: rtl/l1ic_decode.sv
module l1ic_decode
  import l1ic_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_en,
  output logic [ADDR_W-1:0] cpu_idx,
  output logic [ADDR_W-1:0] grp_idx
);
  localparam logic [ADDR_W-1:0] BANK_V  = ADDR_W'(bank_words(NUM_WORDS));
  localparam logic [ADDR_W-1:0] WORDS_V = ADDR_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] CPUS_V  = ADDR_W'(NUM_CPUS);
  localparam logic [ADDR_W-1:0] ONE_V   = ADDR_W'(1);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    cpu_idx = addr / BANK_V;
    offset  = addr % BANK_V;
    hit     = (cpu_idx < CPUS_V);
    is_en   = (offset < WORDS_V);
    // Highest source group sits at the lowest offset of each run
    if (is_en) grp_idx = WORDS_V - ONE_V - offset;
    else       grp_idx = BANK_V - ONE_V - offset;
  end
endmodule

// File: rtl/l1ic_bank.sv
module l1ic_bank
  import l1ic_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int IDX_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_stb,
  input  logic [IDX_W-1:0]                 wr_grp,
  input  word_t                            wr_data,
  input  logic [SRC_PER_WORD*NUM_WORDS-1:0] status,
  output logic [SRC_PER_WORD*NUM_WORDS-1:0] en_flat,
  output logic                             irq
);
  localparam int BITS = SRC_PER_WORD * NUM_WORDS;

  word_t en_q [NUM_WORDS];
  logic  irq_q;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g] <= '0;
      end else if (wr_stb && (wr_grp == IDX_W'(g))) begin
        en_q[g] <= wr_data;
      end
    end
    assign en_flat[g*SRC_PER_WORD +: SRC_PER_WORD] = en_q[g];
  end

  logic [BITS-1:0] live;
  assign live = status & en_flat;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |live;
  end

  assign irq = irq_q;
endmodule

// File: rtl/l1ic_top.sv
module l1ic_top
  import l1ic_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [SRC_PER_WORD*NUM_WORDS-1:0] src_in,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [31:0]                       wr_data,
  output logic [31:0]                       rd_data,
  output logic [NUM_CPUS-1:0]               irq_out
);
  localparam int SRC_W = SRC_PER_WORD * NUM_WORDS;

  logic [SRC_W-1:0]          status;
  logic [NUM_CPUS*SRC_W-1:0] en_all;
  logic                      hit;
  logic                      is_en;
  logic [ADDR_W-1:0]         cpu_idx;
  logic [ADDR_W-1:0]         grp_idx;
  word_t                     rd_mux;
  word_t                     rd_q;

  l1ic_sync #(.WIDTH(SRC_W)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (src_in),
    .d_out (status)
  );

  l1ic_decode #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .addr    (addr),
    .hit     (hit),
    .is_en   (is_en),
    .cpu_idx (cpu_idx),
    .grp_idx (grp_idx)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic stb;
    assign stb = wr_en && hit && is_en && (cpu_idx == ADDR_W'(c));

    l1ic_bank #(
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (ADDR_W)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (stb),
      .wr_grp  (grp_idx),
      .wr_data (wr_data),
      .status  (status),
      .en_flat (en_all[c*SRC_W +: SRC_W]),
      .irq     (irq_out[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        for (int g = 0; g < NUM_WORDS; g++) begin
          if ((cpu_idx == ADDR_W'(c)) && (grp_idx == ADDR_W'(g))) begin
            if (is_en) rd_mux = en_all[c*SRC_W + g*SRC_PER_WORD +: SRC_PER_WORD];
            else       rd_mux = status[g*SRC_PER_WORD +: SRC_PER_WORD];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/l1ic_chk.sv
module l1ic_chk #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 6
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             wr_en,
  input logic                             rd_en,
  input logic [ADDR_W-1:0]                addr,
  input logic [31:0]                      rd_data,
  input logic [NUM_CPUS-1:0]              irq_out,
  input logic [32*NUM_WORDS-1:0]          status,
  input logic [NUM_CPUS*32*NUM_WORDS-1:0] en_all
);
  localparam int BW = 32 * NUM_WORDS;
  localparam int TOTAL = NUM_CPUS * 2 * NUM_WORDS;

  logic in_range;
  logic en_addr;
  assign in_range = (int'(addr) < TOTAL);
  assign en_addr  = in_range && ((int'(addr) % (2 * NUM_WORDS)) < NUM_WORDS);

  AST_RESET_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_out == '0)); // R1

  AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(!(wr_en && en_addr)) |-> $stable(en_all)); // R4

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !in_range) |-> (rd_data == '0)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rd_en) |-> $stable(rd_data)); // R9

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_irq
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
      irq_out[c] == $past(|(status & en_all[c*BW +: BW]))); // R5
  end
endmodule

bind l1ic_top l1ic_chk #(
  .NUM_CPUS  (NUM_CPUS),
  .NUM_WORDS (NUM_WORDS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rd_data (rd_data),
  .irq_out (irq_out),
  .status  (status),
  .en_all  (en_all)
);

// File: tb/test_l1ic_top.sv
module test_l1ic_top;
  localparam int NC = 2;
  localparam int NW = 2;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [63:0]   src_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  l1ic_top #(.NUM_CPUS(NC), .NUM_WORDS(NW), .ADDR_W(AW)) i_l1ic_top (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  // {src[63:0], cpu0 hi, cpu0 lo, cpu1 hi, cpu1 lo, expected irq[1:0]}
  localparam logic [193:0] VEC [0:5] = '{
    {64'h0000_0000_0000_0001, 32'h0, 32'h1, 32'h0, 32'h0, 2'b01},
    {64'h8000_0000_0000_0000, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 2'b10},
    {64'h0000_0001_0000_0000, 32'h1, 32'h0, 32'h1, 32'h0, 2'b11},
    {64'h0000_0000_0000_00FF, 32'h0, 32'hFFFF_FF00, 32'h0, 32'h0, 2'b00},
    {64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 2'b10},
    {64'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input logic [31:0] exp,
                          input string req);
    logic [31:0] v;
    bus_rd(a, v);
    check(v == exp, req, 64'(v), 64'(exp));
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(irq_out == 2'b00, "R1 irq after reset", 64'(irq_out), 64'h0);
    rd_check(0, 32'h0, "R1 cpu0 en hi");
    rd_check(1, 32'h0, "R1 cpu0 en lo");
    rd_check(4, 32'h0, "R1 cpu1 en hi");
    rd_check(5, 32'h0, "R1 cpu1 en lo");

    // Table walk: R2 R3 R5 R7
    for (int i = 0; i < 6; i++) begin
      logic [193:0] e;
      e = VEC[i];
      bus_wr(0, e[129:98]);
      bus_wr(1, e[97:66]);
      bus_wr(4, e[65:34]);
      bus_wr(5, e[33:2]);
      src_in = e[193:130];
      repeat (4) @(negedge clk);
      check(irq_out == e[1:0], "R5 R7 irq vector", 64'(irq_out), 64'(e[1:0]));
      rd_check(0, e[129:98], "R2 cpu0 en hi readback");
      rd_check(5, e[33:2], "R2 cpu1 en lo readback");
      rd_check(2, e[193:162], "R3 status hi");
      rd_check(7, e[161:130], "R3 status lo cpu1 bank");
    end

    // R5: latency from a source edge
    bus_wr(0, 32'h0); bus_wr(1, 32'h8); bus_wr(4, 32'h0); bus_wr(5, 32'h0);
    repeat (3) @(negedge clk);
    src_in = 64'h8;
    @(negedge clk);
    check(irq_out == 2'b00, "R5 edge1", 64'(irq_out), 64'h0);
    @(negedge clk);
    check(irq_out == 2'b00, "R5 edge2", 64'(irq_out), 64'h0);
    @(negedge clk);
    check(irq_out == 2'b01, "R5 edge3", 64'(irq_out), 64'h1);

    // R5 R7: latency from an enable write
    bus_wr(5, 32'h8);
    check(irq_out[1] == 1'b0, "R5 en write same edge", 64'(irq_out), 64'h1);
    @(negedge clk);
    check(irq_out == 2'b11, "R7 both cpus", 64'(irq_out), 64'h3);

    // R4: status write ignored
    bus_wr(3, 32'hFFFF_FFFF);
    bus_wr(2, 32'hFFFF_FFFF);
    rd_check(1, 32'h8, "R4 en lo kept");
    rd_check(0, 32'h0, "R4 en hi kept");
    rd_check(3, 32'h8, "R4 status lo live");
    rd_check(2, 32'h0, "R4 status hi live");

    // R6: bank independence
    bus_wr(4, 32'hA5);
    rd_check(0, 32'h0, "R6 cpu0 hi untouched");
    rd_check(4, 32'hA5, "R6 cpu1 hi written");
    check(irq_out == 2'b11, "R6 irq unchanged", 64'(irq_out), 64'h3);

    // R8: out-of-range
    bus_wr(8, 32'hFFFF_FFFF);
    bus_wr(63, 32'hFFFF_FFFF);
    rd_check(8, 32'h0, "R8 read addr 8");
    rd_check(63, 32'h0, "R8 read addr 63");
    rd_check(0, 32'h0, "R8 cpu0 hi");
    rd_check(1, 32'h8, "R8 cpu0 lo");
    rd_check(4, 32'hA5, "R8 cpu1 hi");
    rd_check(5, 32'h8, "R8 cpu1 lo");

    // R9: hold without strobe
    bus_rd(4, v);
    addr = 0;
    repeat (3) @(negedge clk);
    check(rd_data == 32'hA5, "R9 rd_data held", 64'(rd_data), 64'hA5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule